// File: doc/BRIEF.md
# DMA Channel Control Register Block

This block is the software-visible control and status front end of a single DMA channel that serves one peripheral. A word-aligned register bus reaches four 32-bit registers: a control/status word, a transfer address register, a spare storage word and an address-extension word. The data mover, address translation and the peripheral sit outside the block.

Writes to the control word have side effects. A reset command bit sends a one-cycle reset pulse to the peripheral. A drain command bit is accepted and then cleared. An all-zero write is turned into a drain request. The top nibble always reads back as a fixed version code. The peripheral raises and clears the channel interrupt through two request inputs. A control write with the enable bit clear forces the interrupt output low. The extension word is ORed into the device-supplied address to form the memory address for transfers, and one control bit gives the transfer direction.

Top module: `dma_chan_ctrl`

## Requirements
- R1: The register is selected by byte-address bits [3:2]: 0 = control/status, 1 = address, 2 = spare, 3 = extension. Address bits [1:0] and any bits above bit 3 are ignored, so the 16-byte window repeats.
- R2: After reset the control word reads 0xA0000000, the other three registers read 0, and `irq_o` and `dev_rst_o` are low.
- R3: A write to the control word stores bits [27:0] as shaped by R5 and forces bits [31:28] to the version code 0xA.
- R4: A control write with bit 7 set drives `dev_rst_o` high for exactly the one cycle after the write edge. A control write with bit 7 clear gives no pulse.
- R5: If bit 7 of a control write is clear and bit 6 (drain) is set, bit 6 is stored as 0. If the whole write value is 0, bit 6 is stored as 1, so the word reads 0xA0000040. If bit 7 is set, bit 6 is stored as written.
- R6: A control write with bit 4 (interrupt enable) clear drives `irq_o` low from the next cycle, unless a device set request arrives in the same cycle. With bit 4 set, `irq_o` is left unchanged.
- R7: `dev_irq_set` sets control bit 0 and raises `irq_o`. `dev_irq_clr` clears bit 0 and lowers `irq_o`. Both take effect on the next cycle. When both arrive together the set wins, and device requests override a same-cycle write on bit 0.
- R8: Any write to the address register stores the data and sets control bit 26 (loaded).
- R9: `mem_addr_o` equals `dev_addr_i` ORed with the extension register, and `xfer_to_mem_o` equals control bit 8 (1 = write to memory).
- R10: A read returns the selected register on `bus_rdata` with `bus_rvalid` high in the cycle after the request. A read changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | REG_W | Write data |
| bus_rdata | output | REG_W | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read |
| dev_irq_set | input | 1 | Peripheral interrupt raise request |
| dev_irq_clr | input | 1 | Peripheral interrupt clear request |
| irq_o | output | 1 | Channel interrupt line |
| dev_rst_o | output | 1 | One-cycle reset pulse to the peripheral |
| dev_addr_i | input | REG_W | Device-supplied transfer address |
| mem_addr_o | output | REG_W | Memory address presented for transfers |
| xfer_to_mem_o | output | 1 | Transfer direction, 1 = write to memory |

## Verification
The bench builds the block with 32-bit registers, the 0xA version code and a 6-bit bus address instead of the default 4 bits. The two extra address bits let it drive addresses above the 16-byte window and show that the window repeats and that the low byte-lane bits are ignored. Random mixes of control, address and extension writes, device requests and reads are checked against a bench model. This reaches the drain and reset shaping and the collisions between device requests and writes on the interrupt bit.

// File: rtl/dmacc_pkg.sv
// Shared constants and types for the DMA channel control block.
// Assumes 32-bit registers; bit positions are fixed by software convention.
package dmacc_pkg;
    typedef enum logic [1:0] {
        RI_CTRL  = 2'd0,
        RI_ADDR  = 2'd1,
        RI_SPARE = 2'd2,
        RI_EXT   = 2'd3
    } reg_idx_t;

    localparam int NUM_REGS   = 4;
    localparam int IDX_LO     = 2;   // word-aligned: byte lanes below
    localparam int IDX_W      = 2;
    localparam int BIT_IRQ    = 0;
    localparam int BIT_IEN    = 4;
    localparam int BIT_DRAIN  = 6;
    localparam int BIT_RESET  = 7;
    localparam int BIT_TOMEM  = 8;
    localparam int BIT_LOADED = 26;
    localparam int VER_W      = 4;
endpackage

// File: rtl/dmacc_decode.sv
// Address decode: turns a bus strobe into one-hot register write enables
// and a read request with the register index. Assumes ADDR_W >= 4; bits
// outside [3:2] are deliberately ignored so the window aliases.
module dmacc_decode #(
    parameter int ADDR_W = 4
) (
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    output logic [dmacc_pkg::NUM_REGS-1:0] wr_en,
    output logic              rd_req,
    output logic [dmacc_pkg::IDX_W-1:0] rd_idx
);
    import dmacc_pkg::*;

    logic [IDX_W-1:0] idx;
    logic             unused_addr_bits;

    // Purpose: extract the word index and absorb the ignored address bits.
    always_comb begin
        idx              = bus_addr[IDX_LO +: IDX_W];
        unused_addr_bits = ^{bus_addr[IDX_LO-1:0], bus_addr[ADDR_W-1:IDX_LO]};
    end

    // Purpose: one write enable per register, built by a generate loop.
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_wen
        assign wr_en[g] = bus_sel && bus_wr && (idx == g[IDX_W-1:0]);
    end

    // Purpose: read request and index for the registered read port.
    always_comb begin
        rd_req = bus_sel && !bus_wr;
        rd_idx = idx;
    end
endmodule

// File: rtl/dmacc_ctrl_word.sv
// Control/status word with its write-side effects, the interrupt line and
// the peripheral reset pulse. Assumes at most one bus write per cycle.
// Device interrupt requests take priority over a same-cycle bus write.
module dmacc_ctrl_word #(
    parameter int               REG_W   = 32,
    parameter logic [3:0]       VERSION = 4'hA
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wdata,
    input  logic             addr_loaded,
    input  logic             irq_set,
    input  logic             irq_clr,
    output logic [REG_W-1:0] ctrl_q,
    output logic             irq_o,
    output logic             dev_rst_o
);
    import dmacc_pkg::*;

    localparam logic [REG_W-1:0] RESET_VAL = {VERSION, {(REG_W-VER_W){1'b0}}};

    logic [REG_W-1:0] shaped;
    logic [REG_W-1:0] ctrl_d;
    logic             irq_d;

    // Purpose: apply reset/drain/zero rules and stamp the version nibble.
    always_comb begin
        shaped = wdata;
        if (wdata[BIT_RESET]) begin
            shaped = wdata;
        end else if (wdata[BIT_DRAIN]) begin
            shaped[BIT_DRAIN] = 1'b0;
        end else if (wdata == '0) begin
            shaped[BIT_DRAIN] = 1'b1;
        end
        shaped[REG_W-1 -: VER_W] = VERSION;
    end

    // Purpose: next control word, device requests last so they win bit 0.
    always_comb begin
        ctrl_d = ctrl_q;
        if (wr_en) begin
            ctrl_d = shaped;
        end
        if (addr_loaded) begin
            ctrl_d[BIT_LOADED] = 1'b1;
        end
        if (irq_set) begin
            ctrl_d[BIT_IRQ] = 1'b1;
        end else if (irq_clr) begin
            ctrl_d[BIT_IRQ] = 1'b0;
        end
    end

    // Purpose: next interrupt line level; set beats clear beats write.
    always_comb begin
        irq_d = irq_o;
        if (irq_set) begin
            irq_d = 1'b1;
        end else if (irq_clr) begin
            irq_d = 1'b0;
        end else if (wr_en && !wdata[BIT_IEN]) begin
            irq_d = 1'b0;
        end
    end

    // Purpose: state registers for control word, interrupt and reset pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q    <= RESET_VAL;
            irq_o     <= 1'b0;
            dev_rst_o <= 1'b0;
        end else begin
            ctrl_q    <= ctrl_d;
            irq_o     <= irq_d;
            dev_rst_o <= wr_en && wdata[BIT_RESET];
        end
    end
endmodule

// File: rtl/dmacc_data_reg.sv
// Plain storage register written whole by the bus. Reset value is zero.
module dmacc_data_reg #(
    parameter int REG_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] q
);
    // Purpose: load on write enable, clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (wr_en) begin
            q <= wdata;
        end
    end
endmodule

// File: rtl/dmacc_rd_port.sv
// Registered read port: selects a register and presents it one cycle
// after the request with a valid flag. Has no effect on register state.
module dmacc_rd_port #(
    parameter int REG_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_req,
    input  logic [dmacc_pkg::IDX_W-1:0] rd_idx,
    input  logic [REG_W-1:0] regs [dmacc_pkg::NUM_REGS],
    output logic [REG_W-1:0] rdata,
    output logic             rvalid
);
    // Purpose: capture the selected word and the valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata  <= '0;
            rvalid <= 1'b0;
        end else begin
            rvalid <= rd_req;
            if (rd_req) begin
                rdata <= regs[rd_idx];
            end
        end
    end
endmodule

// File: rtl/dma_chan_ctrl.sv
// DMA channel control register block. Four word registers in a 16-byte
// window; control word side effects, interrupt line, peripheral reset
// pulse and memory address extension. Assumes REG_W = 32, ADDR_W >= 4.
module dma_chan_ctrl #(
    parameter int         REG_W   = 32,
    parameter int         ADDR_W  = 4,
    parameter logic [3:0] VERSION = 4'hA
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    output logic              bus_rvalid,
    input  logic              dev_irq_set,
    input  logic              dev_irq_clr,
    output logic              irq_o,
    output logic              dev_rst_o,
    input  logic [REG_W-1:0]  dev_addr_i,
    output logic [REG_W-1:0]  mem_addr_o,
    output logic              xfer_to_mem_o
);
    import dmacc_pkg::*;

    logic [NUM_REGS-1:0] wr_en;
    logic                rd_req;
    logic [IDX_W-1:0]    rd_idx;
    logic [REG_W-1:0]    regs [NUM_REGS];

    dmacc_decode #(.ADDR_W(ADDR_W)) u_decode (
        .bus_sel  (bus_sel),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .wr_en    (wr_en),
        .rd_req   (rd_req),
        .rd_idx   (rd_idx)
    );

    dmacc_ctrl_word #(.REG_W(REG_W), .VERSION(VERSION)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en[RI_CTRL]),
        .wdata       (bus_wdata),
        .addr_loaded (wr_en[RI_ADDR]),
        .irq_set     (dev_irq_set),
        .irq_clr     (dev_irq_clr),
        .ctrl_q      (regs[RI_CTRL]),
        .irq_o       (irq_o),
        .dev_rst_o   (dev_rst_o)
    );

    // Plain registers: address, spare and extension share one template.
    for (genvar g = 1; g < NUM_REGS; g++) begin : g_data
        dmacc_data_reg #(.REG_W(REG_W)) u_reg (
            .clk   (clk),
            .rst_n (rst_n),
            .wr_en (wr_en[g]),
            .wdata (bus_wdata),
            .q     (regs[g])
        );
    end

    dmacc_rd_port #(.REG_W(REG_W)) u_rd (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_req (rd_req),
        .rd_idx (rd_idx),
        .regs   (regs),
        .rdata  (bus_rdata),
        .rvalid (bus_rvalid)
    );

    // Purpose: transfer address formation and direction.
    always_comb begin
        mem_addr_o    = dev_addr_i | regs[RI_EXT];
        xfer_to_mem_o = regs[RI_CTRL][BIT_TOMEM];
    end
endmodule

// File: rtl/dmacc_chk.sv
// Port-level assertion checker for dma_chan_ctrl, attached by bind.
module dmacc_chk #(
    parameter int         REG_W   = 32,
    parameter int         ADDR_W  = 4,
    parameter logic [3:0] VERSION = 4'hA
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [REG_W-1:0]  bus_wdata,
    input logic [REG_W-1:0]  bus_rdata,
    input logic              bus_rvalid,
    input logic              dev_irq_set,
    input logic              dev_irq_clr,
    input logic              irq_o,
    input logic              dev_rst_o
);
    logic ctrl_wr;
    logic ctrl_rd;
    assign ctrl_wr = bus_sel && bus_wr && (bus_addr[3:2] == 2'd0);
    assign ctrl_rd = bus_sel && !bus_wr && (bus_addr[3:2] == 2'd0);

    AST_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        dev_rst_o |=> !dev_rst_o); // R4
    AST_RST_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && bus_wdata[7]) |=> dev_rst_o); // R4
    AST_VERSION_READ: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_rd |=> (bus_rdata[REG_W-1 -: 4] == VERSION)); // R3
    AST_IEN_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && !bus_wdata[4] && !dev_irq_set) |=> !irq_o); // R6
    AST_IRQ_SET: assert property (@(posedge clk) disable iff (!rst_n)
        dev_irq_set |=> irq_o); // R7
    AST_IRQ_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_irq_clr && !dev_irq_set) |=> !irq_o); // R7
    AST_RD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr) |=> bus_rvalid); // R10
    AST_RD_ONLY_ON_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (!(bus_sel && !bus_wr)) |=> !bus_rvalid); // R10
endmodule

bind dma_chan_ctrl dmacc_chk #(
    .REG_W(REG_W), .ADDR_W(ADDR_W), .VERSION(VERSION)
) u_dmacc_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_sel     (bus_sel),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .bus_rvalid  (bus_rvalid),
    .dev_irq_set (dev_irq_set),
    .dev_irq_clr (dev_irq_clr),
    .irq_o       (irq_o),
    .dev_rst_o   (dev_rst_o)
);

// File: tb/test_dma_chan_ctrl.sv
// Self-checking bench: directed corners plus seeded random operations
// compared against a bench-side register model.
module test_dma_chan_ctrl;
    localparam int REG_W  = 32;
    localparam int ADDR_W = 6;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_sel = 1'b0;
    logic              bus_wr = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [REG_W-1:0]  bus_wdata = '0;
    logic [REG_W-1:0]  bus_rdata;
    logic              bus_rvalid;
    logic              dev_irq_set = 1'b0;
    logic              dev_irq_clr = 1'b0;
    logic              irq_o;
    logic              dev_rst_o;
    logic [REG_W-1:0]  dev_addr_i = '0;
    logic [REG_W-1:0]  mem_addr_o;
    logic              xfer_to_mem_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    // bench model
    logic [31:0] m_reg [4];
    logic        m_irq;

    always #10 clk = ~clk;  // 50 MHz

    dma_chan_ctrl #(.REG_W(REG_W), .ADDR_W(ADDR_W), .VERSION(4'hA)) i_dma_chan_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .dev_irq_set(dev_irq_set),
        .dev_irq_clr(dev_irq_clr), .irq_o(irq_o), .dev_rst_o(dev_rst_o),
        .dev_addr_i(dev_addr_i), .mem_addr_o(mem_addr_o),
        .xfer_to_mem_o(xfer_to_mem_o)
    );

    function automatic logic [31:0] exp_ctrl(input logic [31:0] d);
        logic [31:0] v = d;
        if (!d[7]) begin
            if (d[6]) v[6] = 1'b0;
            else if (d == 32'd0) v[6] = 1'b1;
        end
        v[31:28] = 4'hA;
        return v;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    function automatic logic [ADDR_W-1:0] mk_addr(input int idx);
        logic [ADDR_W-1:0] a;
        a = ADDR_W'($urandom);
        a[3:2] = idx[1:0];
        return a;
    endfunction

    // write; returns with registers updated, sampled at a negedge
    task automatic bus_write(input int idx, input logic [31:0] d, input string req);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = mk_addr(idx); bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
        if (idx == 0) begin
            check(req, {31'd0, dev_rst_o}, {31'd0, d[7]});   // R4 pulse
            m_reg[0] = exp_ctrl(d);
            if (!d[4]) m_irq = 1'b0;                           // R6
        end else begin
            check(req, {31'd0, dev_rst_o}, 32'd0);             // R4 no pulse
            m_reg[idx] = d;
            if (idx == 1) m_reg[0][26] = 1'b1;                 // R8
        end
        @(negedge clk);
        check("R4 pulse ends", {31'd0, dev_rst_o}, 32'd0);
    endtask

    task automatic bus_read(input int idx, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = mk_addr(idx);
        @(negedge clk);
        bus_sel = 1'b0;
        check("R10 rvalid", {31'd0, bus_rvalid}, 32'd1);
        d = bus_rdata;
    endtask

    task automatic read_check(input int idx, input string req);
        logic [31:0] d;
        bus_read(idx, d);
        check(req, d, m_reg[idx]);
    endtask

    task automatic dev_req(input logic s, input logic c);
        @(negedge clk);
        dev_irq_set = s; dev_irq_clr = c;
        @(negedge clk);
        dev_irq_set = 1'b0; dev_irq_clr = 1'b0;
        if (s) begin m_irq = 1'b1; m_reg[0][0] = 1'b1; end
        else if (c) begin m_irq = 1'b0; m_reg[0][0] = 1'b0; end
        check("R7 irq line", {31'd0, irq_o}, {31'd0, m_irq});
    endtask

    initial begin
        #(20 * 150000);
        $display("FAIL watchdog: actual hung expected done");
        n_checks++; n_fail++;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        logic [31:0] d, d2;
        void'($urandom(32'd20240611));
        m_reg[0] = 32'hA000_0000; m_reg[1] = '0; m_reg[2] = '0; m_reg[3] = '0;
        m_irq = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R2 reset state
        check("R2 irq", {31'd0, irq_o}, 32'd0);
        check("R2 dev_rst", {31'd0, dev_rst_o}, 32'd0);
        for (int i = 0; i < 4; i++) read_check(i, "R2 reset value");

        // R5 directed shaping corners
        bus_write(0, 32'h0000_0000, "R5 zero write");
        read_check(0, "R5 zero becomes drain 0xA0000040");
        bus_write(0, 32'h0000_0050, "R5 drain self clears");
        read_check(0, "R5 drain cleared");
        bus_write(0, 32'hFFFF_FFFF, "R4 reset bit with drain");
        read_check(0, "R3 R5 reset keeps drain, version forced");

        // R8 load flag
        bus_write(0, 32'h0000_0010, "R3 plain");
        bus_write(1, 32'h1234_5678, "R8 address write");
        read_check(1, "R8 address stored");
        read_check(0, "R8 loaded bit");

        // R7 interrupt paths
        dev_req(1'b1, 1'b0);
        read_check(0, "R7 bit0 set");
        dev_req(1'b0, 1'b1);
        read_check(0, "R7 bit0 cleared");
        dev_req(1'b1, 1'b1);
        read_check(0, "R7 set wins");
        // R6 enable set keeps irq high; enable clear drops it
        bus_write(0, 32'h0000_0011, "R6 enable set");
        check("R6 irq kept", {31'd0, irq_o}, {31'd0, m_irq});
        bus_write(0, 32'h0000_0001, "R6 enable clear");
        check("R6 irq dropped", {31'd0, irq_o}, 32'd0);
        // R7 set overriding same-cycle write on bit 0
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = mk_addr(0); bus_wdata = 32'h0;
        dev_irq_set = 1'b1;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; dev_irq_set = 1'b0;
        m_reg[0] = exp_ctrl(32'h0); m_reg[0][0] = 1'b1; m_irq = 1'b1;
        check("R7 set beats write irq", {31'd0, irq_o}, 32'd1);
        read_check(0, "R7 set beats write bit0");

        // R1 aliasing: random upper and lane bits already in mk_addr
        bus_write(2, 32'hCAFE_F00D, "R1 spare");
        read_check(2, "R1 spare alias");

        // R10 read has no side effect
        bus_read(0, d);
        bus_read(0, d2);
        check("R10 repeat read stable", d2, d);

        // R9 address formation and direction
        bus_write(3, 32'h8000_0003, "R9 ext");
        dev_addr_i = 32'h0012_3450;
        @(negedge clk);
        check("R9 mem addr", mem_addr_o, 32'h8012_3453);
        check("R9 direction", {31'd0, xfer_to_mem_o}, {31'd0, m_reg[0][8]});

        // random mix
        for (int it = 0; it < 300; it++) begin
            int op = $urandom_range(0, 5);
            logic [31:0] rv = $urandom;
            if ($urandom_range(0, 7) == 0) rv = 32'd0;
            case (op)
                0: bus_write(0, rv, "R3 R5 random ctrl");
                1: bus_write(int'($urandom_range(1, 3)), rv, "R1 R8 random data");
                2: dev_req(1'($urandom), 1'($urandom));
                3: read_check(int'($urandom_range(0, 3)), "R3 R10 random read");
                4: begin
                    dev_addr_i = $urandom;
                    @(negedge clk);
                    check("R9 random mem addr", mem_addr_o, dev_addr_i | m_reg[3]);
                    check("R9 random dir", {31'd0, xfer_to_mem_o}, {31'd0, m_reg[0][8]});
                end
                default: check("R6 R7 irq model", {31'd0, irq_o}, {31'd0, m_irq});
            endcase
        end
        for (int i = 0; i < 4; i++) read_check(i, "R10 final");

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule